// File: doc/BRIEF.md
# Limit Monitor with Sticky Status and Alert-Response Answerer

This block watches three measured quantities of a battery monitor against programmable upper and lower limits. Charge is a 16-bit value that is watched on every clock. Voltage and temperature are watched only when a new conversion result arrives. Every limit breach sets a sticky bit in a status byte. Two further bits record events from neighbouring logic: accumulator saturation and recovery from undervoltage. A host read of the status byte clears each bit only if its cause has gone away.

When the pin mode selects alert operation, a new breach or saturation event pulls an open-drain alert line low. The block then takes part in the SMBus alert response cycle. It decodes the alert response address from already-sampled SCL/SDA levels and acknowledges it. It then sends its own 7-bit address followed by a 1, under wired-AND arbitration. If it loses arbitration, it stays silent until the next START. If it wins, it releases the alert line and does not answer again until a fresh event occurs.

There are no streaming data paths. Every port is a plain level or a single-cycle strobe, so no valid/ready handshake exists and nothing applies back-pressure.

Top module: `thresh_alert_unit`

## Requirements
- R1: After reset the status byte is 00h, and both the alert and SDA pull-downs are off. Status bits 7 and 6 always read 0.
- R2: Status bit 3 is set when the charge is strictly above its 16-bit upper limit, and bit 2 when it is strictly below its 16-bit lower limit. Both are evaluated every cycle, and equality never sets either bit.
- R3: Status bit 1 is set when, on a voltage update strobe, the result's upper byte is strictly above the 8-bit upper limit or strictly below the 8-bit lower limit. A changed voltage value without a strobe has no effect.
- R4: Status bit 4 follows the same rule as R3, applied to the temperature upper byte, its 8-bit limits and its own strobe.
- R5: An accumulator saturation pulse sets status bit 5. An undervoltage-recovery pulse sets status bit 0.
- R6: Status bits are sticky. A read strobe clears a bit only if its cause is absent in that cycle; otherwise the bit stays 1.
- R7: The alert pull-down is active only when pin mode is 2'b10 and an alert is pending. A pending alert is raised by a 0-to-1 change of status bits 5..1; bit 0 never raises one.
- R8: After START, the block answers with an acknowledge (SDA low during the ninth clock) only if the byte is 0001100 followed by read=1 and the alert pull-down is active.
- R9: After its acknowledge, the block sends 11001001 MSB first. It changes its SDA pull-down only while SCL is low.
- R10: If the block releases SDA to send a 1 but samples SDA low at an SCL rising edge, it stops driving for the rest of the transfer. It keeps its alert pending and can answer at the next START.
- R11: When a byte is sent without losing arbitration, the pending alert is cleared. A later alert response gets no acknowledge until a new event per R7 occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chg_val | input | 16 | Accumulated charge |
| chg_hi | input | 16 | Charge upper limit |
| chg_lo | input | 16 | Charge lower limit |
| volt_top | input | 8 | Upper byte of voltage result |
| volt_upd | input | 1 | Voltage result update strobe |
| volt_hi | input | 8 | Voltage upper limit |
| volt_lo | input | 8 | Voltage lower limit |
| temp_top | input | 8 | Upper byte of temperature result |
| temp_upd | input | 1 | Temperature result update strobe |
| temp_hi | input | 8 | Temperature upper limit |
| temp_lo | input | 8 | Temperature lower limit |
| sat_evt | input | 1 | Accumulator saturation pulse |
| uv_evt | input | 1 | Undervoltage recovery pulse |
| pin_mode | input | 2 | Alert pin mode, 2'b10 enables alert output |
| stat_rd | input | 1 | Status byte read strobe |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| start_det | input | 1 | START condition pulse |
| stop_det | input | 1 | STOP condition pulse |
| stat_byte | output | 8 | Status byte |
| alert_pd | output | 1 | Alert line pull-down enable |
| sda_pd | output | 1 | SDA pull-down enable |

## Verification
The hardest state to reach is losing arbitration partway through the address byte. It needs a pending alert, a valid alert response address, and a second bus talker that pulls SDA low in a bit where this block sends a 1. The bench models SDA as a wired-AND of master, competitor and block, and has the competitor drive a lower address. It checks that the block never pulls SDA again in that byte and still holds its alert. A clean cycle follows, and then a third cycle checks that the answer is withheld.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int FLAG_N = 6;
  localparam int B_UV   = 0;
  localparam int B_VOLT = 1;
  localparam int B_CLO  = 2;
  localparam int B_CHI  = 3;
  localparam int B_TEMP = 4;
  localparam int B_SAT  = 5;
  localparam logic [FLAG_N-1:0] ALERT_MASK = 6'b111110;

  typedef enum logic [2:0] {
    RSP_IDLE,
    RSP_ADDR,
    RSP_ACK,
    RSP_TX,
    RSP_MACK
  } rsp_state_t;
endpackage

// File: rtl/thr_window_cmp.sv
module thr_window_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic         above,
  output logic         below
);
  always_comb begin
    above = (val > hi);
    below = (val < lo);
  end
endmodule

// File: rtl/thr_meas_cond.sv
module thr_meas_cond #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] val,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic         cond
);
  logic above, below, cond_q;

  thr_window_cmp #(.W(W)) u_cmp (
    .val(val), .hi(hi), .lo(lo), .above(above), .below(below)
  );

  always_comb cond = upd ? (above | below) : cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(cond_q)) else $error("hold"); // R3
endmodule

// File: rtl/thr_status_bank.sv
module thr_status_bank
  import thr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] set_vec,
  input  logic              rd,
  input  logic              ara_done,
  output logic [FLAG_N-1:0] flags,
  output logic              alert_req
);
  logic [FLAG_N-1:0] flags_q;
  logic              alert_q;
  logic              new_evt;

  always_comb new_evt = |(set_vec & ~flags_q & ALERT_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      alert_q <= 1'b0;
    end else begin
      flags_q <= set_vec | (flags_q & ~{FLAG_N{rd}});
      alert_q <= new_evt | (alert_q & ~ara_done);
    end
  end

  assign flags     = flags_q;
  assign alert_req = alert_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((flags_q & $past(flags_q)) == $past(flags_q))) else $error("sticky"); // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_done && !new_evt) |=> !alert_q) else $error("release"); // R11
  AST_UV_NO_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_q && !(|(set_vec & ALERT_MASK))) |=> !alert_q) else $error("uvalert"); // R7
endmodule

// File: rtl/ara_responder.sv
module ara_responder
  import thr_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'b1100100,
  parameter logic [6:0] ARA_ADDR = 7'b0001100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic start_det,
  input  logic stop_det,
  input  logic alert_on,
  output logic sda_pd,
  output logic done
);
  localparam logic [7:0] ARA_BYTE = {ARA_ADDR, 1'b1};
  localparam logic [7:0] TX_BYTE  = {OWN_ADDR, 1'b1};

  rsp_state_t st;
  logic       scl_q, pd_q, done_q;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic [7:0] shnext;
  logic [2:0] tx_idx;
  logic       scl_rise, scl_fall;

  always_comb begin
    scl_rise = scl_in & ~scl_q;
    scl_fall = ~scl_in & scl_q;
    shnext   = {shreg[6:0], sda_in};
    tx_idx   = 3'(4'd7 - cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RSP_IDLE;
      scl_q  <= 1'b1;
      pd_q   <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else begin
      scl_q  <= scl_in;
      done_q <= 1'b0;
      if (start_det) begin
        st   <= RSP_ADDR;
        cnt  <= '0;
        pd_q <= 1'b0;
      end else if (stop_det) begin
        st   <= RSP_IDLE;
        pd_q <= 1'b0;
      end else begin
        case (st)
          RSP_ADDR: if (scl_rise) begin
            shreg <= shnext;
            cnt   <= cnt + 4'd1;
            if (cnt == 4'd7)
              st <= (shnext == ARA_BYTE && alert_on) ? RSP_ACK : RSP_IDLE;
          end
          RSP_ACK: if (scl_fall) begin
            if (!pd_q) pd_q <= 1'b1;
            else begin
              pd_q <= ~TX_BYTE[7];
              cnt  <= 4'd1;
              st   <= RSP_TX;
            end
          end
          RSP_TX: begin
            if (scl_rise && !pd_q && !sda_in) begin
              pd_q <= 1'b0;
              st   <= RSP_IDLE;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                pd_q <= 1'b0;
                st   <= RSP_MACK;
              end else begin
                pd_q <= ~TX_BYTE[tx_idx];
                cnt  <= cnt + 4'd1;
              end
            end
          end
          RSP_MACK: if (scl_rise) begin
            done_q <= 1'b1;
            st     <= RSP_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pd = pd_q;
  assign done   = done_q;

  AST_ACK_NEEDS_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RSP_ACK && $past(st) == RSP_ADDR) |-> $past(alert_on)) else $error("ack"); // R8
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_q) |-> !$past(scl_in)) else $error("sdachg"); // R9
  AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RSP_TX && scl_rise && !pd_q && !sda_in && !start_det && !stop_det)
      |=> (!pd_q && st == RSP_IDLE)) else $error("lost"); // R10
endmodule

// File: rtl/thresh_alert_unit.sv
module thresh_alert_unit
  import thr_pkg::*;
#(
  parameter int CHG_W = 16,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CHG_W-1:0] chg_val,
  input  logic [CHG_W-1:0] chg_hi,
  input  logic [CHG_W-1:0] chg_lo,
  input  logic [LIM_W-1:0] volt_top,
  input  logic             volt_upd,
  input  logic [LIM_W-1:0] volt_hi,
  input  logic [LIM_W-1:0] volt_lo,
  input  logic [LIM_W-1:0] temp_top,
  input  logic             temp_upd,
  input  logic [LIM_W-1:0] temp_hi,
  input  logic [LIM_W-1:0] temp_lo,
  input  logic             sat_evt,
  input  logic             uv_evt,
  input  logic [1:0]       pin_mode,
  input  logic             stat_rd,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             start_det,
  input  logic             stop_det,
  output logic [7:0]       stat_byte,
  output logic             alert_pd,
  output logic             sda_pd
);
  localparam int NQ = 2;

  logic [LIM_W-1:0]  q_val [NQ];
  logic [LIM_W-1:0]  q_hi  [NQ];
  logic [LIM_W-1:0]  q_lo  [NQ];
  logic [NQ-1:0]     q_upd;
  logic [NQ-1:0]     q_cond;
  logic              chg_above, chg_below;
  logic [FLAG_N-1:0] set_vec, flags;
  logic              alert_req, ara_done;

  always_comb begin
    q_val[0] = volt_top; q_hi[0] = volt_hi; q_lo[0] = volt_lo; q_upd[0] = volt_upd;
    q_val[1] = temp_top; q_hi[1] = temp_hi; q_lo[1] = temp_lo; q_upd[1] = temp_upd;
  end

  thr_window_cmp #(.W(CHG_W)) u_chg (
    .val(chg_val), .hi(chg_hi), .lo(chg_lo), .above(chg_above), .below(chg_below)
  );

  for (genvar g = 0; g < NQ; g++) begin : g_meas
    thr_meas_cond #(.W(LIM_W)) u_cond (
      .clk(clk), .rst_n(rst_n), .upd(q_upd[g]), .val(q_val[g]),
      .hi(q_hi[g]), .lo(q_lo[g]), .cond(q_cond[g])
    );
  end

  always_comb begin
    set_vec         = '0;
    set_vec[B_UV]   = uv_evt;
    set_vec[B_VOLT] = q_cond[0];
    set_vec[B_CLO]  = chg_below;
    set_vec[B_CHI]  = chg_above;
    set_vec[B_TEMP] = q_cond[1];
    set_vec[B_SAT]  = sat_evt;
  end

  thr_status_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd(stat_rd),
    .ara_done(ara_done), .flags(flags), .alert_req(alert_req)
  );

  assign stat_byte = {2'b00, flags};
  assign alert_pd  = alert_req && (pin_mode == 2'b10);

  ara_responder u_rsp (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .start_det(start_det), .stop_det(stop_det), .alert_on(alert_pd),
    .sda_pd(sda_pd), .done(ara_done)
  );

  AST_CHG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_val > chg_hi) |=> stat_byte[3]) else $error("chghi"); // R2
  AST_CHG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_val < chg_lo) |=> stat_byte[2]) else $error("chglo"); // R2
  AST_ALERT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    alert_pd |-> (pin_mode == 2'b10)) else $error("mode"); // R7
endmodule

// File: tb/thresh_alert_unit_bench.sv
module thresh_alert_unit_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [15:0] chg_val, chg_hi, chg_lo;
  logic [7:0]  volt_top, volt_hi, volt_lo, temp_top, temp_hi, temp_lo;
  logic volt_upd, temp_upd, sat_evt, uv_evt, stat_rd, start_det, stop_det;
  logic [1:0] pin_mode;
  logic scl_m, sda_m, sda_c, sda_bus;
  logic [7:0] stat_byte;
  logic alert_pd, sda_pd;
  int n_run = 0, n_fail = 0;

  assign sda_bus = sda_m & sda_c & ~sda_pd;

  thresh_alert_unit u_thresh_alert_unit (
    .clk(clk), .rst_n(rst_n), .chg_val(chg_val), .chg_hi(chg_hi), .chg_lo(chg_lo),
    .volt_top(volt_top), .volt_upd(volt_upd), .volt_hi(volt_hi), .volt_lo(volt_lo),
    .temp_top(temp_top), .temp_upd(temp_upd), .temp_hi(temp_hi), .temp_lo(temp_lo),
    .sat_evt(sat_evt), .uv_evt(uv_evt), .pin_mode(pin_mode), .stat_rd(stat_rd),
    .scl_in(scl_m), .sda_in(sda_bus), .start_det(start_det), .stop_det(stop_det),
    .stat_byte(stat_byte), .alert_pd(alert_pd), .sda_pd(sda_pd)
  );

  // {charge, upper limit, lower limit, expected {bit3, bit2}}
  localparam logic [49:0] CHG_VEC [7] = '{
    {16'h8000, 16'hFFFF, 16'h0000, 2'b00},
    {16'hFFFF, 16'hFFFF, 16'h0000, 2'b00},
    {16'h0000, 16'hFFFF, 16'h0000, 2'b00},
    {16'h1235, 16'h1234, 16'h0000, 2'b10},
    {16'h0FFF, 16'hFFFF, 16'h1000, 2'b01},
    {16'h1234, 16'h1234, 16'h1234, 2'b00},
    {16'h0500, 16'h0400, 16'h0600, 2'b11}
  };

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1; hold(1); stat_rd = 1'b0; hold(1);
  endtask

  task automatic bus_start();
    scl_m = 1'b1; sda_m = 1'b1; hold(4);
    sda_m = 1'b0; start_det = 1'b1; hold(1); start_det = 1'b0; hold(3);
    scl_m = 1'b0; hold(4);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; hold(4);
    scl_m = 1'b1; hold(4);
    sda_m = 1'b1; stop_det = 1'b1; hold(1); stop_det = 1'b0; hold(4);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hold(3); scl_m = 1'b1; hold(4); scl_m = 1'b0; hold(1);
  endtask

  task automatic get_bit(input logic comp, output logic b, output logic pd);
    sda_m = 1'b1; sda_c = comp; hold(3); scl_m = 1'b1; hold(2);
    b = sda_bus; pd = sda_pd; hold(2); scl_m = 1'b0; hold(1); sda_c = 1'b1;
  endtask

  task automatic ara_cycle(input logic [7:0] addr, input logic [7:0] comp,
                           output logic ack, output logic [7:0] rx, output logic pd_late);
    logic b, pd;
    rx = 8'h00; pd_late = 1'b0;
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(addr[i]);
    get_bit(1'b1, ack, pd);
    if (!ack) begin
      for (int i = 7; i >= 0; i--) begin
        get_bit(comp[i], b, pd);
        rx[i] = b;
        if (i < 7 && pd) pd_late = 1'b1;
      end
      put_bit(1'b1);
    end
    bus_stop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic ack, pdl;
    logic [7:0] rx;
    rst_n = 1'b0; chg_val = 16'h8000; chg_hi = 16'hFFFF; chg_lo = 16'h0000;
    volt_top = 8'h50; volt_hi = 8'hFF; volt_lo = 8'h00; volt_upd = 1'b0;
    temp_top = 8'h50; temp_hi = 8'hFF; temp_lo = 8'h00; temp_upd = 1'b0;
    sat_evt = 1'b0; uv_evt = 1'b0; pin_mode = 2'b00; stat_rd = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; sda_c = 1'b1; start_det = 1'b0; stop_det = 1'b0;
    hold(3); rst_n = 1'b1; hold(2);
    chk("R1 reset status", stat_byte, 8'h00);
    chk("R1 reset alert/sda", {alert_pd, sda_pd}, 2'b00);

    // R2 table walk
    for (int k = 0; k < 7; k++) begin
      {chg_val, chg_hi, chg_lo} = CHG_VEC[k][49:2];
      hold(2);
      chk("R2 charge window", stat_byte[3:2], CHG_VEC[k][1:0]);
      chg_val = 16'h8000; chg_hi = 16'hFFFF; chg_lo = 16'h0000;
      pulse_rd();
      chk("R6 charge cleared", stat_byte[3:2], 2'b00);
    end

    // R3 voltage
    volt_hi = 8'h80; volt_top = 8'h81; hold(2);
    chk("R3 no strobe no effect", stat_byte[1], 1'b0);
    volt_upd = 1'b1; hold(1); volt_upd = 1'b0; hold(1);
    chk("R3 above limit", stat_byte[1], 1'b1);
    volt_top = 8'h80; volt_upd = 1'b1; hold(1); volt_upd = 1'b0; hold(1);
    chk("R6 sticky after cause gone", stat_byte[1], 1'b1);
    pulse_rd();
    chk("R6 read clears gone cause", stat_byte[1], 1'b0);
    volt_top = 8'h90; volt_upd = 1'b1; hold(1); volt_upd = 1'b0; hold(1);
    pulse_rd();
    chk("R6 read keeps present cause", stat_byte[1], 1'b1);
    volt_top = 8'h70; volt_upd = 1'b1; hold(1); volt_upd = 1'b0; hold(1);
    pulse_rd();
    chk("R3 cleared", stat_byte[1], 1'b0);

    // R4 temperature
    temp_lo = 8'h40; temp_top = 8'h3F; temp_upd = 1'b1; hold(1); temp_upd = 1'b0; hold(1);
    chk("R4 below limit", stat_byte[4], 1'b1);
    temp_top = 8'h40; temp_upd = 1'b1; hold(1); temp_upd = 1'b0; hold(1);
    pulse_rd();
    chk("R4 equal low clears", stat_byte[4], 1'b0);
    temp_hi = 8'hA0; temp_top = 8'hA1; temp_upd = 1'b1; hold(1); temp_upd = 1'b0; hold(1);
    chk("R4 above limit", stat_byte[4], 1'b1);
    temp_top = 8'hA0; temp_upd = 1'b1; hold(1); temp_upd = 1'b0; hold(1);
    pulse_rd();
    chk("R4 equal high clears", stat_byte[4], 1'b0);

    // R5 events
    sat_evt = 1'b1; uv_evt = 1'b1; hold(1); sat_evt = 1'b0; uv_evt = 1'b0; hold(1);
    chk("R5 event bits", stat_byte, 8'h21);
    chk("R7 mode 00 no alert", alert_pd, 1'b0);
    pulse_rd();
    chk("R5 events clear on read", stat_byte, 8'h00);

    // R7/R8/R10/R11 alert response
    pin_mode = 2'b10; hold(1);
    chk("R7 pending alert drives line", alert_pd, 1'b1);
    ara_cycle(8'h1B, 8'hFF, ack, rx, pdl);
    chk("R8 wrong address nack", ack, 1'b1);
    ara_cycle(8'h19, 8'h10, ack, rx, pdl);
    chk("R8 ack while alert", ack, 1'b0);
    chk("R10 silent after loss", pdl, 1'b0);
    chk("R10 alert kept after loss", alert_pd, 1'b1);
    ara_cycle(8'h19, 8'hFF, ack, rx, pdl);
    chk("R8 ack clean cycle", ack, 1'b0);
    chk("R9 sent byte", rx, 8'hC9);
    chk("R11 alert released", alert_pd, 1'b0);
    chk("R9 sda released", sda_pd, 1'b0);
    ara_cycle(8'h19, 8'hFF, ack, rx, pdl);
    chk("R11 no answer without new event", ack, 1'b1);
    uv_evt = 1'b1; hold(1); uv_evt = 1'b0; hold(1);
    chk("R7 undervoltage raises no alert", alert_pd, 1'b0);
    sat_evt = 1'b1; hold(1); sat_evt = 1'b0; hold(1);
    chk("R7 new event raises alert", alert_pd, 1'b1);
    pin_mode = 2'b01; hold(1);
    chk("R7 other mode no alert", alert_pd, 1'b0);
    chk("R1 top bits zero", stat_byte[7:6], 2'b00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule